// File: doc/BRIEF.md
# Synchronous External-Bus to FIFO Bridge

This block is the FPGA-side slave for a host processor's synchronous parallel memory bus. Every bus signal is sampled on the single bus clock. The chip-select, write-strobe and output-enable inputs are all active low. When chip-select and write-strobe are both low, the cycle is a host write, and the word on the bus is pushed into a receive FIFO. When chip-select and output-enable are both low, the cycle is a host read, and a word is popped from a transmit FIFO and driven onto the bus. During a burst, one word moves in each clock.

The host may program a read latency and a write latency, each from 0 to 3 bus clocks. The strobe decode is delayed by that many clocks, so the push or pop lines up with the first bus cycle that carries valid data. Both FIFOs are 16 words deep and run in the bus clock domain. On the FPGA side, the receive FIFO has a ready/valid read port and the transmit FIFO has a ready/valid write port. The data bus has separate input and output buses plus an output-enable, which the pad ring turns into a tri-state pin.

Top module: `bus_fifo_bridge`

## Requirements
- R1: Synchronous active-high reset has these effects: rx_valid=0, tx_ready=1, both flags 0 and bus_d_oe=0. Both latency pipelines are cleared.
- R2: Suppose bus_cs_n=0 and bus_we_n=0 are sampled at edge t with wr_lat=L. Then at edge t+L, the value on bus_d_in is pushed into the receive FIFO. In a burst, one word is pushed per clock.
- R3: Suppose bus_cs_n=0 and bus_oe_n=0 are sampled at edge t with rd_lat=L. Then at edge t+L, one word is popped from the transmit FIFO. In the following cycle, bus_d_oe=1 and bus_d_out holds that word.
- R4: bus_d_oe is 0 in every cycle that does not follow a pop edge.
- R5: The receive FIFO returns words in arrival order and holds up to 16 of them. rx_valid=1 exactly when it is not empty. A word leaves when rx_valid and rx_ready are both 1 at an edge.
- R6: A bus push into a full receive FIFO is dropped and sets rx_overflow, which is sticky. The push is not dropped if rx_ready drains a word at the same edge.
- R7: A bus pop from an empty transmit FIFO drives zero and sets tx_underflow, which is sticky. A word pushed by tx_valid at the same edge does not count as present.
- R8: err_clr=1 at an edge clears both flags. If a flag's set event occurs at the same edge, the set wins.
- R9: tx_ready=1 exactly when the transmit FIFO holds fewer than 16 words. A word enters when tx_valid and tx_ready are both 1 at an edge.
- R10: A strobe sampled while bus_cs_n=1 causes neither a push nor a pop.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_cs_n | input | 1 | Chip select, active low |
| bus_we_n | input | 1 | Host write strobe, active low |
| bus_oe_n | input | 1 | Host read strobe, active low |
| bus_d_in | input | DW | Data from the bus pins |
| bus_d_out | output | DW | Data to drive onto the bus |
| bus_d_oe | output | 1 | Drive enable for bus_d_out |
| rd_lat | input | 2 | Read latency in clocks, 0 to 3 |
| wr_lat | input | 2 | Write latency in clocks, 0 to 3 |
| rx_data | output | DW | Head of the receive FIFO |
| rx_valid | output | 1 | Receive FIFO not empty |
| rx_ready | input | 1 | FPGA logic accepts rx_data |
| tx_data | input | DW | Word offered to the transmit FIFO |
| tx_valid | input | 1 | tx_data is valid |
| tx_ready | output | 1 | Transmit FIFO has room |
| err_clr | input | 1 | Clears both sticky flags |
| rx_overflow | output | 1 | Sticky: a bus write was dropped |
| tx_underflow | output | 1 | Sticky: a bus read found no data |

## Verification
Two pairs of events can land on the same edge. The first is a delayed bus push into a full receive FIFO while the FPGA side drains it. The second is a transmit underflow while err_clr is asserted. The bench fills the receive FIFO with rx_ready held low, then writes again with rx_ready high: the word must be accepted and no overflow must be raised. It also reads an empty transmit FIFO with err_clr high, where the flag must still end up set. A queue-based reference model judges both cases, and the same model runs alongside random traffic in which drain, clear and bus strobes collide freely.

// File: rtl/bus_fifo_bridge.sv
module bus_fifo_bridge #(
  parameter int DW     = 32,
  parameter int DEPTH  = 16,
  parameter int MAXLAT = 3
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          bus_cs_n,
  input  logic          bus_we_n,
  input  logic          bus_oe_n,
  input  logic [DW-1:0] bus_d_in,
  output logic [DW-1:0] bus_d_out,
  output logic          bus_d_oe,
  input  logic [1:0]    rd_lat,
  input  logic [1:0]    wr_lat,
  output logic [DW-1:0] rx_data,
  output logic          rx_valid,
  input  logic          rx_ready,
  input  logic [DW-1:0] tx_data,
  input  logic          tx_valid,
  output logic          tx_ready,
  input  logic          err_clr,
  output logic          rx_overflow,
  output logic          tx_underflow
);
  localparam int AW = $clog2(DEPTH);
  localparam logic [AW:0] FULLCNT = (AW+1)'(DEPTH);

  // strobe decode and latency pipelines
  logic wr_act, rd_act;
  assign wr_act = ~bus_cs_n & ~bus_we_n;
  assign rd_act = ~bus_cs_n & ~bus_oe_n;

  logic [MAXLAT:1] wr_pipe, rd_pipe;
  always_ff @(posedge clk) begin
    if (rst) begin
      wr_pipe <= '0;
      rd_pipe <= '0;
    end else begin
      wr_pipe <= {wr_pipe[MAXLAT-1:1], wr_act};
      rd_pipe <= {rd_pipe[MAXLAT-1:1], rd_act};
    end
  end

  logic [MAXLAT:0] wr_taps, rd_taps;
  assign wr_taps = {wr_pipe, wr_act};
  assign rd_taps = {rd_pipe, rd_act};

  logic bus_push, bus_pop;
  assign bus_push = wr_taps[wr_lat];
  assign bus_pop  = rd_taps[rd_lat];

  // receive FIFO: bus in, ready/valid out
  logic [DW-1:0] rx_mem [DEPTH];
  logic [AW-1:0] rx_wp, rx_rp;
  logic [AW:0]   rx_cnt;
  logic          rx_full, rx_pop, rx_push;

  assign rx_full  = rx_cnt == FULLCNT;
  assign rx_valid = rx_cnt != '0;
  assign rx_data  = rx_mem[rx_rp];
  assign rx_pop   = rx_valid & rx_ready;
  assign rx_push  = bus_push & (~rx_full | rx_pop);

  always_ff @(posedge clk) begin
    if (rst) begin
      rx_wp  <= '0;
      rx_rp  <= '0;
      rx_cnt <= '0;
    end else begin
      if (rx_push) rx_wp <= rx_wp + 1'b1;
      if (rx_pop)  rx_rp <= rx_rp + 1'b1;
      rx_cnt <= rx_cnt + (AW+1)'(rx_push) - (AW+1)'(rx_pop);
    end
  end

  always_ff @(posedge clk)
    if (rx_push) rx_mem[rx_wp] <= bus_d_in;

  // transmit FIFO: ready/valid in, bus out
  logic [DW-1:0] tx_mem [DEPTH];
  logic [AW-1:0] tx_wp, tx_rp;
  logic [AW:0]   tx_cnt;
  logic          tx_empty, tx_push, tx_take;

  assign tx_empty = tx_cnt == '0;
  assign tx_ready = tx_cnt != FULLCNT;
  assign tx_push  = tx_valid & tx_ready;
  assign tx_take  = bus_pop & ~tx_empty;

  always_ff @(posedge clk) begin
    if (rst) begin
      tx_wp  <= '0;
      tx_rp  <= '0;
      tx_cnt <= '0;
    end else begin
      if (tx_push) tx_wp <= tx_wp + 1'b1;
      if (tx_take) tx_rp <= tx_rp + 1'b1;
      tx_cnt <= tx_cnt + (AW+1)'(tx_push) - (AW+1)'(tx_take);
    end
  end

  always_ff @(posedge clk)
    if (tx_push) tx_mem[tx_wp] <= tx_data;

  // bus output register
  always_ff @(posedge clk) begin
    if (rst) begin
      bus_d_out <= '0;
      bus_d_oe  <= 1'b0;
    end else begin
      bus_d_oe <= bus_pop;
      if (bus_pop) bus_d_out <= tx_empty ? '0 : tx_mem[tx_rp];
    end
  end

  // sticky flags, set wins over clear
  logic ovf_set, udf_set;
  assign ovf_set = bus_push & ~rx_push;
  assign udf_set = bus_pop & tx_empty;

  always_ff @(posedge clk) begin
    if (rst) begin
      rx_overflow  <= 1'b0;
      tx_underflow <= 1'b0;
    end else begin
      rx_overflow  <= ovf_set | (rx_overflow  & ~err_clr);
      tx_underflow <= udf_set | (tx_underflow & ~err_clr);
    end
  end

  p_drive_after_pop_r3: assert property (@(posedge clk) disable iff (rst)
    bus_pop |=> bus_d_oe);

  p_release_idle_r4: assert property (@(posedge clk) disable iff (rst)
    !bus_pop |=> !bus_d_oe);

  p_rx_bound_r5: assert property (@(posedge clk) disable iff (rst)
    rx_cnt <= FULLCNT);

  p_no_drop_on_drain_r6: assert property (@(posedge clk) disable iff (rst)
    (bus_push && rx_pop) |=> !$fell(rx_valid));

  p_overflow_sticky_r6: assert property (@(posedge clk) disable iff (rst)
    (rx_overflow && !err_clr) |=> rx_overflow);

  p_underflow_zero_r7: assert property (@(posedge clk) disable iff (rst)
    (bus_pop && tx_empty) |=> (bus_d_out == '0 && tx_underflow));

  p_clear_r8: assert property (@(posedge clk) disable iff (rst)
    (err_clr && !udf_set) |=> !tx_underflow);

  p_cs_gates_r10: assert property (@(posedge clk) disable iff (rst)
    (bus_cs_n && !rx_pop && $past(bus_cs_n) && wr_pipe == '0) |=> $stable(rx_cnt));
endmodule

// File: tb/tb_bus_fifo_bridge.sv
module tb_bus_fifo_bridge;
  localparam int DW = 32;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst = 1'b1;
  logic bus_cs_n = 1, bus_we_n = 1, bus_oe_n = 1;
  logic [DW-1:0] bus_d_in = '0, tx_data = '0;
  logic [1:0] rd_lat = 0, wr_lat = 0;
  logic rx_ready = 0, tx_valid = 0, err_clr = 0;
  logic [DW-1:0] bus_d_out, rx_data;
  logic bus_d_oe, rx_valid, tx_ready, rx_overflow, tx_underflow;

  bus_fifo_bridge #(.DW(DW), .DEPTH(16), .MAXLAT(3)) dut (
    .clk(clk), .rst(rst), .bus_cs_n(bus_cs_n), .bus_we_n(bus_we_n),
    .bus_oe_n(bus_oe_n), .bus_d_in(bus_d_in), .bus_d_out(bus_d_out),
    .bus_d_oe(bus_d_oe), .rd_lat(rd_lat), .wr_lat(wr_lat),
    .rx_data(rx_data), .rx_valid(rx_valid), .rx_ready(rx_ready),
    .tx_data(tx_data), .tx_valid(tx_valid), .tx_ready(tx_ready),
    .err_clr(err_clr), .rx_overflow(rx_overflow), .tx_underflow(tx_underflow));

  int errors = 0, checks = 0;
  bit done = 0;

  // reference model state
  logic [DW-1:0] rxq[$], txq[$];
  bit [2:0] hw, hr;
  bit exp_oe, exp_ovf, exp_udf, last_clr, last_udf_pop, phase_r10, rnd_side;
  logic [DW-1:0] exp_dout;

  function automatic bit tap(input bit [2:0] hist, input bit now, input logic [1:0] lat);
    bit [3:0] t;
    t = {hist, now};
    return t[lat];
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      rxq.delete(); txq.delete();
      hw = 0; hr = 0; exp_oe = 0; exp_ovf = 0; exp_udf = 0; exp_dout = '0;
      last_clr = 0; last_udf_pop = 0;
    end else begin
      bit wa, ra, push, pop, rpop, accept, txin, oset, uset;
      wa = !bus_cs_n && !bus_we_n;
      ra = !bus_cs_n && !bus_oe_n;
      push = tap(hw, wa, wr_lat);
      pop  = tap(hr, ra, rd_lat);
      hw = {hw[1:0], wa};
      hr = {hr[1:0], ra};
      rpop = rx_ready && rxq.size() > 0;
      accept = push && (rxq.size() < 16 || rpop);
      oset = push && !accept;
      if (rpop) void'(rxq.pop_front());
      if (accept) rxq.push_back(bus_d_in);
      txin = tx_valid && txq.size() < 16;
      uset = 0;
      last_udf_pop = 0;
      if (pop) begin
        if (txq.size() > 0) exp_dout = txq.pop_front();
        else begin exp_dout = '0; uset = 1; last_udf_pop = 1; end
      end
      if (txin) txq.push_back(tx_data);
      exp_oe = pop;
      exp_ovf = oset || (exp_ovf && !err_clr);
      exp_udf = uset || (exp_udf && !err_clr);
      last_clr = err_clr;
    end
  end

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic check_all();
    chk(bus_d_oe == exp_oe, exp_oe ? "R3" : "R4", 64'(bus_d_oe), 64'(exp_oe));
    if (exp_oe) chk(bus_d_out == exp_dout, last_udf_pop ? "R7" : "R3", 64'(bus_d_out), 64'(exp_dout));
    chk(rx_valid == (rxq.size() > 0), phase_r10 ? "R10" : "R5", 64'(rx_valid), 64'(rxq.size() > 0));
    if (rxq.size() > 0) chk(rx_data == rxq[0], "R2", 64'(rx_data), 64'(rxq[0]));
    chk(tx_ready == (txq.size() < 16), "R9", 64'(tx_ready), 64'(txq.size() < 16));
    chk(rx_overflow == exp_ovf, last_clr ? "R8" : "R6", 64'(rx_overflow), 64'(exp_ovf));
    chk(tx_underflow == exp_udf, last_clr ? "R8" : "R7", 64'(tx_underflow), 64'(exp_udf));
  endtask

  task automatic cyc();
    if (rnd_side) begin
      rx_ready = ($urandom % 4) != 0;
      tx_valid = $urandom % 2;
      tx_data  = $urandom;
      err_clr  = ($urandom % 20) == 0;
    end
    bus_d_in = $urandom;
    @(negedge clk);
    check_all();
  endtask

  task automatic idle(input int n);
    bus_cs_n = 1; bus_we_n = 1; bus_oe_n = 1;
    for (int i = 0; i < n; i++) cyc();
  endtask

  task automatic wburst(input int n);
    bus_cs_n = 0; bus_we_n = 0; bus_oe_n = 1;
    for (int i = 0; i < n; i++) cyc();
    idle(4);
  endtask

  task automatic rburst(input int n);
    bus_cs_n = 0; bus_we_n = 1; bus_oe_n = 0;
    for (int i = 0; i < n; i++) cyc();
    idle(4);
  endtask

  initial begin
    void'($urandom(32'h5eed1234));
    rnd_side = 0;
    repeat (3) @(negedge clk);
    rst = 0;
    // R1 reset state
    chk(rx_valid == 0, "R1", 64'(rx_valid), 0);
    chk(tx_ready == 1, "R1", 64'(tx_ready), 1);
    chk(bus_d_oe == 0, "R1", 64'(bus_d_oe), 0);
    chk(rx_overflow == 0 && tx_underflow == 0, "R1", 64'({rx_overflow, tx_underflow}), 0);

    // R6: overflow with receive side stalled
    wr_lat = 2; rx_ready = 0; tx_valid = 0; err_clr = 0;
    wburst(20);
    err_clr = 1; idle(1); err_clr = 0;
    // R6: full FIFO drained at the same edge as a bus push
    wr_lat = 0; rx_ready = 1;
    wburst(5);
    // R7: reads from empty transmit FIFO, then R8 set wins over clear
    rd_lat = 1;
    rburst(3);
    err_clr = 1; rburst(2); err_clr = 0;
    idle(2);
    // R10: strobes without chip select
    phase_r10 = 1;
    bus_cs_n = 1; bus_we_n = 0; bus_oe_n = 1;
    for (int i = 0; i < 5; i++) cyc();
    bus_we_n = 1; bus_oe_n = 0;
    for (int i = 0; i < 5; i++) cyc();
    phase_r10 = 0;
    idle(4);

    // R9: fill transmit FIFO, then random traffic
    tx_valid = 1;
    for (int i = 0; i < 20; i++) begin tx_data = $urandom; idle(1); end
    rnd_side = 1;
    for (int k = 0; k < 120; k++) begin
      rd_lat = $urandom % 4;
      wr_lat = $urandom % 4;
      case ($urandom % 3)
        0: wburst(1 + $urandom % 20);
        1: rburst(1 + $urandom % 20);
        default: idle(1 + $urandom % 6);
      endcase
    end
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      errors++;
      checks++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule